// File: doc/BRIEF.md
# Parallel Panel Write Interface

This block drives an 8080-style parallel write bus towards a display panel that keeps its own frame memory. Each pixel word is sent as one write cycle. Chip select goes low, the interface waits through a chip-select setup phase and a write setup phase, and then pulls the write strobe low for the active phase. After the strobe is released, a hold phase follows and chip select returns high. The length of each phase is programmed in a 32-bit configuration word.

A transfer always covers a whole frame of `FRAME_WORDS` pixel words, taken in order from a valid/ready pixel stream. There are two ways to start a frame:
- **Immediate mode:** the transfer begins as soon as software writes the trigger command.
- **Tearing-effect mode:** the command only arms a request, and the frame starts on the next rising edge of the panel's tearing-effect input.

At the end of the frame the block sets a sticky done flag and raises a one-cycle interrupt pulse. The done flag is cleared by writing one to it. A frame has to complete before the next tearing-effect pulse, so the clock is normally run at twice the rate that the display timing alone would need.

Top module: `panel_wr_if`

## Requirements
- R1: After reset, `lcd_cs_n` and `lcd_wr_n` are 1, and `busy`, `done_flag` and `irq` are 0.
- R2: The configuration word holds the enable at bit 0. It holds the chip-select setup length at bits 19:16, the write setup length at bits 15:12, the active length at bits 11:8 and the hold length at bits 7:4. A trigger command written while enable is 0 is dropped, and enabling the interface later does not revive it.
- R3: Each word cycle keeps chip select low while the write strobe is high for exactly (chip-select setup + write setup) cycles before the strobe falls. The strobe then stays low for the active length. Chip select stays low for exactly the hold length after the strobe rises, then returns high.
- R4: An active length of 0 gives a strobe low time of 1 cycle. Reset loads an active length of 1, zero setup and hold lengths, and enable 0.
- R5: The trigger write carries a mode at bit 0 and a command at bit 1. With mode 0, the command starts a frame without waiting. With mode 1, the command only arms a request, and `busy` rises at the clock edge where a rising edge of `te_in` is first seen.
- R6: A trigger command written while `busy` is 1 is ignored, and no second frame follows.
- R7: An armed request clears itself when its frame starts. A later `te_in` edge with no new command starts nothing.
- R8: A frame produces exactly `FRAME_WORDS` strobe pulses. The data bus carries the stream words in order and holds steady while chip select is low.
- R9: On the clock edge that ends the last hold (or active) phase, `busy` falls, `done_flag` sets, and `irq` goes high for exactly one cycle.
- R10: A pulse on `done_clr` clears `done_flag`.
- R11: A word cycle does not begin (chip select stays high) until a pixel word is accepted with `pix_valid` and `pix_ready` both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration word write strobe |
| cfg_wdata | input | 32 | Configuration word (enable and four phase lengths) |
| trig_we | input | 1 | Trigger write strobe |
| trig_wdata | input | 2 | Bit 0 mode (1 = wait for tearing edge), bit 1 start command |
| done_clr | input | 1 | Write-one-to-clear of the done flag |
| te_in | input | 1 | Tearing-effect input from the panel |
| pix_valid | input | 1 | Pixel stream word valid |
| pix_data | input | DW | Pixel stream word |
| pix_ready | output | 1 | Pixel word accepted this cycle |
| lcd_cs_n | output | 1 | Panel chip select, active low |
| lcd_wr_n | output | 1 | Panel write strobe, active low |
| lcd_data | output | DW | Panel data bus |
| busy | output | 1 | Frame transfer in progress |
| done_flag | output | 1 | Sticky frame-done status |
| irq | output | 1 | One-cycle frame-done interrupt |

## Verification
A phase counter loaded with a wrong value shows up within one word as a setup, strobe or hold length that differs from the programmed fields. A wrong word count shows up at the end of the frame as too many or too few strobe pulses, or as a missing or repeated interrupt. A pending request that fails to clear is exposed only by the next tearing edge, which would then start an unwanted frame. The bench therefore fires such edges deliberately after every armed frame.

// File: rtl/pwi_pkg.sv
`timescale 1ns/1ps
package pwi_pkg;

    localparam int TW            = 4;
    localparam int CFG_EN_BIT    = 0;
    localparam int CSS_LSB       = 16;
    localparam int WRS_LSB       = 12;
    localparam int ACT_LSB       = 8;
    localparam int HOLD_LSB      = 4;
    localparam int TRIG_MODE_BIT = 0;
    localparam int TRIG_CMD_BIT  = 1;

    typedef logic [TW-1:0] tlen_t;

    typedef struct packed {
        logic  en;
        tlen_t css;
        tlen_t wrs;
        tlen_t act;
        tlen_t hold;
    } pwi_cfg_t;

    typedef enum logic [2:0] {
        PH_FETCH = 3'd0,
        PH_CSS   = 3'd1,
        PH_WRS   = 3'd2,
        PH_ACT   = 3'd3,
        PH_HOLD  = 3'd4
    } pwi_phase_e;

    typedef struct packed {
        pwi_phase_e ph;
        tlen_t      cnt;
        logic       word_end;
    } pwi_step_t;

    localparam pwi_cfg_t CFG_RESET = '{en: 1'b0, css: '0, wrs: '0,
                                       act: tlen_t'(1), hold: '0};

    // strobe low time never drops below one cycle
    function automatic tlen_t act_cycles(input tlen_t a);
        return (a == '0) ? tlen_t'(1) : a;
    endfunction

    // phase entered once 'cur' has run out, with its counter preload
    function automatic pwi_step_t step_after(input pwi_phase_e cur, input pwi_cfg_t c);
        pwi_step_t s;
        s.ph       = PH_FETCH;
        s.cnt      = '0;
        s.word_end = 1'b0;
        unique case (cur)
            PH_FETCH: begin
                if (c.css != '0) begin
                    s.ph  = PH_CSS;
                    s.cnt = c.css - tlen_t'(1);
                end else if (c.wrs != '0) begin
                    s.ph  = PH_WRS;
                    s.cnt = c.wrs - tlen_t'(1);
                end else begin
                    s.ph  = PH_ACT;
                    s.cnt = act_cycles(c.act) - tlen_t'(1);
                end
            end
            PH_CSS: begin
                if (c.wrs != '0) begin
                    s.ph  = PH_WRS;
                    s.cnt = c.wrs - tlen_t'(1);
                end else begin
                    s.ph  = PH_ACT;
                    s.cnt = act_cycles(c.act) - tlen_t'(1);
                end
            end
            PH_WRS: begin
                s.ph  = PH_ACT;
                s.cnt = act_cycles(c.act) - tlen_t'(1);
            end
            PH_ACT: begin
                if (c.hold != '0) begin
                    s.ph  = PH_HOLD;
                    s.cnt = c.hold - tlen_t'(1);
                end else begin
                    s.word_end = 1'b1;
                end
            end
            default: s.word_end = 1'b1;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/pwi_trig_regs.sv
`timescale 1ns/1ps
module pwi_trig_regs
    import pwi_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        cfg_we,
    input  logic [31:0] cfg_wdata,
    input  logic        trig_we,
    input  logic [1:0]  trig_wdata,
    input  logic        te_in,
    input  logic        busy,
    input  logic        start_ack,
    output pwi_cfg_t    cfg,
    output logic        start_req
);

    pwi_cfg_t cfg_q;
    logic     mode_q;
    logic     pend_q;
    logic     te_q;
    logic     te_rise;
    logic     unused_cfg_bits;

    assign unused_cfg_bits = ^{cfg_wdata[31:20], cfg_wdata[3:1]};
    assign te_rise         = te_in & ~te_q;
    assign cfg             = cfg_q;
    assign start_req       = pend_q & cfg_q.en & (~mode_q | te_rise);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q  <= CFG_RESET;
            mode_q <= 1'b0;
            pend_q <= 1'b0;
            te_q   <= 1'b0;
        end else begin
            te_q <= te_in;
            if (cfg_we) begin
                cfg_q.en   <= cfg_wdata[CFG_EN_BIT];
                cfg_q.css  <= cfg_wdata[CSS_LSB  +: TW];
                cfg_q.wrs  <= cfg_wdata[WRS_LSB  +: TW];
                cfg_q.act  <= cfg_wdata[ACT_LSB  +: TW];
                cfg_q.hold <= cfg_wdata[HOLD_LSB +: TW];
            end
            if (trig_we)
                mode_q <= trig_wdata[TRIG_MODE_BIT];
            if (start_ack)
                pend_q <= 1'b0;
            else if (trig_we && trig_wdata[TRIG_CMD_BIT] && cfg_q.en && !busy)
                pend_q <= 1'b1;
        end
    end

    AST_PEND_CLEARS: assert property (@(posedge clk) disable iff (rst)
        start_ack |=> !pend_q); // R7

    AST_NO_ARM_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
        (!pend_q && !cfg_q.en) |=> !pend_q); // R2

endmodule

// File: rtl/pwi_frame_ctl.sv
`timescale 1ns/1ps
module pwi_frame_ctl #(
    parameter int FRAME_WORDS = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic start_req,
    input  logic word_end,
    input  logic done_clr,
    output logic start_ack,
    output logic busy,
    output logic done_flag,
    output logic irq
);

    localparam int CW = (FRAME_WORDS > 1) ? $clog2(FRAME_WORDS) : 1;
    localparam logic [CW-1:0] LAST_IDX = CW'(FRAME_WORDS - 1);

    logic          busy_q;
    logic          done_q;
    logic          irq_q;
    logic [CW-1:0] wcnt_q;
    logic          frame_end;

    assign start_ack = start_req & ~busy_q;
    assign frame_end = busy_q & word_end & (wcnt_q == LAST_IDX);
    assign busy      = busy_q;
    assign done_flag = done_q;
    assign irq       = irq_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            done_q <= 1'b0;
            irq_q  <= 1'b0;
            wcnt_q <= '0;
        end else begin
            irq_q <= 1'b0;
            if (done_clr)
                done_q <= 1'b0;
            if (start_ack) begin
                busy_q <= 1'b1;
                wcnt_q <= '0;
            end else if (frame_end) begin
                busy_q <= 1'b0;
                done_q <= 1'b1;
                irq_q  <= 1'b1;
            end else if (busy_q && word_end) begin
                wcnt_q <= wcnt_q + CW'(1);
            end
        end
    end

    AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (rst)
        irq_q |=> !irq_q); // R9

    AST_IRQ_AT_END: assert property (@(posedge clk) disable iff (rst)
        irq_q |-> (!busy_q && $past(busy_q) && done_q)); // R9

endmodule

// File: rtl/pwi_phase_seq.sv
`timescale 1ns/1ps
module pwi_phase_seq
    import pwi_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          run,
    input  pwi_cfg_t      cfg,
    input  logic          pix_valid,
    input  logic [DW-1:0] pix_data,
    output logic          pix_ready,
    output logic          cs_n,
    output logic          wr_n,
    output logic [DW-1:0] lcd_data,
    output logic          word_end
);

    pwi_phase_e    ph_q;
    tlen_t         cnt_q;
    logic [DW-1:0] data_q;
    pwi_step_t     nxt;
    logic          take;
    logic          advance;

    assign pix_ready = run && (ph_q == PH_FETCH);
    assign take      = pix_ready && pix_valid;
    assign nxt       = step_after(ph_q, cfg);
    assign advance   = (ph_q == PH_FETCH) ? take : (cnt_q == '0);
    assign word_end  = advance && nxt.word_end;
    assign cs_n      = (ph_q == PH_FETCH);
    assign wr_n      = (ph_q != PH_ACT);
    assign lcd_data  = data_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q   <= PH_FETCH;
            cnt_q  <= '0;
            data_q <= '0;
        end else begin
            if (take)
                data_q <= pix_data;
            if (advance) begin
                ph_q  <= nxt.ph;
                cnt_q <= nxt.cnt;
            end else if (ph_q != PH_FETCH) begin
                cnt_q <= cnt_q - tlen_t'(1);
            end
        end
    end

    AST_CS_NEEDS_PIXEL: assert property (@(posedge clk) disable iff (rst)
        $fell(cs_n) |-> $past(pix_valid && pix_ready)); // R11

    AST_DATA_HELD: assert property (@(posedge clk) disable iff (rst)
        (!cs_n && !$past(cs_n)) |-> $stable(lcd_data)); // R8

    AST_STROBE_IN_FRAME: assert property (@(posedge clk) disable iff (rst)
        $fell(wr_n) |-> $past(run)); // R3

endmodule

// File: rtl/panel_wr_if.sv
`timescale 1ns/1ps
module panel_wr_if
    import pwi_pkg::*;
#(
    parameter int DW          = 16,
    parameter int FRAME_WORDS = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cfg_we,
    input  logic [31:0]   cfg_wdata,
    input  logic          trig_we,
    input  logic [1:0]    trig_wdata,
    input  logic          done_clr,
    input  logic          te_in,
    input  logic          pix_valid,
    input  logic [DW-1:0] pix_data,
    output logic          pix_ready,
    output logic          lcd_cs_n,
    output logic          lcd_wr_n,
    output logic [DW-1:0] lcd_data,
    output logic          busy,
    output logic          done_flag,
    output logic          irq
);

    pwi_cfg_t cfg;
    logic     start_req;
    logic     start_ack;
    logic     word_end;

    pwi_trig_regs u_regs (
        .clk        (clk),
        .rst        (rst),
        .cfg_we     (cfg_we),
        .cfg_wdata  (cfg_wdata),
        .trig_we    (trig_we),
        .trig_wdata (trig_wdata),
        .te_in      (te_in),
        .busy       (busy),
        .start_ack  (start_ack),
        .cfg        (cfg),
        .start_req  (start_req)
    );

    pwi_frame_ctl #(.FRAME_WORDS(FRAME_WORDS)) u_frame (
        .clk       (clk),
        .rst       (rst),
        .start_req (start_req),
        .word_end  (word_end),
        .done_clr  (done_clr),
        .start_ack (start_ack),
        .busy      (busy),
        .done_flag (done_flag),
        .irq       (irq)
    );

    pwi_phase_seq #(.DW(DW)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .run       (busy),
        .cfg       (cfg),
        .pix_valid (pix_valid),
        .pix_data  (pix_data),
        .pix_ready (pix_ready),
        .cs_n      (lcd_cs_n),
        .wr_n      (lcd_wr_n),
        .lcd_data  (lcd_data),
        .word_end  (word_end)
    );

    AST_IDLE_BUS: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (lcd_cs_n && lcd_wr_n)); // R8

    AST_BUSY_STARTS_ONLY_ON_REQ: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(start_req)); // R6

endmodule

// File: tb/panel_wr_if_tb_top.sv
`timescale 1ns/1ps
module panel_wr_if_tb_top;

    localparam int DW = 16;
    localparam int FW = 16;

    // {css, wrs, act, hold, exp_pre, exp_act, exp_post}, one nibble each
    localparam logic [27:0] VEC [6] = '{
        28'h0010010, 28'h1010110, 28'h0231231,
        28'h2113313, 28'h3342642, 28'h0000010
    };

    logic          clk = 1'b0;
    logic          rst;
    logic          cfg_we, trig_we, done_clr, te_in, pix_valid;
    logic [31:0]   cfg_wdata;
    logic [1:0]    trig_wdata;
    logic [DW-1:0] pix_data;
    logic          pix_ready, lcd_cs_n, lcd_wr_n, busy, done_flag, irq;
    logic [DW-1:0] lcd_data;

    int n_chk = 0;
    int n_err = 0;

    int pulses, data_err, tim_err, irq_cnt;
    int pre_r, act_r, post_r, bad_trip;
    int exp_pre, exp_act, exp_post;
    logic [DW-1:0] exp_data;
    logic seen, prev_cs, prev_wr;

    always #2 clk = ~clk;

    panel_wr_if #(.DW(DW), .FRAME_WORDS(FW)) dut_i (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .trig_we(trig_we), .trig_wdata(trig_wdata), .done_clr(done_clr),
        .te_in(te_in), .pix_valid(pix_valid), .pix_data(pix_data),
        .pix_ready(pix_ready), .lcd_cs_n(lcd_cs_n), .lcd_wr_n(lcd_wr_n),
        .lcd_data(lcd_data), .busy(busy), .done_flag(done_flag), .irq(irq)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic write_cfg(input int css, input int wrs, input int act, input int hold, input bit en);
        cfg_wdata = {12'd0, 4'(css), 4'(wrs), 4'(act), 4'(hold), 3'd0, en};
        cfg_we    = 1'b1;
        tick(1);
        cfg_we    = 1'b0;
    endtask

    task automatic write_trig(input bit mode, input bit cmd);
        trig_wdata = {cmd, mode};
        trig_we    = 1'b1;
        tick(1);
        trig_we    = 1'b0;
    endtask

    task automatic arm_mon(input int p, input int a, input int h);
        exp_pre = p; exp_act = a; exp_post = h;
        pulses = 0; data_err = 0; tim_err = 0; irq_cnt = 0; bad_trip = 0;
        exp_data = pix_data;
    endtask

    task automatic wait_done(input int maxc);
        for (int k = 0; k < maxc; k++) begin
            if (done_flag) break;
            tick(1);
        end
    endtask

    task automatic clear_done(input string tag);
        done_clr = 1'b1;
        tick(1);
        done_clr = 1'b0;
        tick(1);
        check(done_flag == 1'b0, tag, done_flag, 0);
    endtask

    // pixel stream: next word after every accepted one
    initial begin
        pix_data = 16'h1200;
        forever begin
            @(posedge clk);
            if (pix_ready && pix_valid) pix_data <= pix_data + 16'd1;
        end
    end

    // bus monitor
    initial begin
        prev_cs = 1'b1; prev_wr = 1'b1; seen = 1'b0;
        pre_r = 0; act_r = 0; post_r = 0;
        forever begin
            @(negedge clk);
            if (irq) irq_cnt++;
            if (!lcd_cs_n) begin
                if (!lcd_wr_n) begin
                    if (prev_wr) begin
                        pulses++;
                        if (lcd_data !== exp_data) data_err++;
                        exp_data = exp_data + 16'd1;
                    end
                    act_r++;
                    seen = 1'b1;
                end else if (!seen) pre_r++;
                else post_r++;
            end else if (!prev_cs) begin
                if (pre_r != exp_pre || act_r != exp_act || post_r != exp_post) begin
                    tim_err++;
                    bad_trip = pre_r * 100 + act_r * 10 + post_r;
                end
                pre_r = 0; act_r = 0; post_r = 0; seen = 1'b0;
            end
            prev_cs = lcd_cs_n;
            prev_wr = lcd_wr_n;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        rst = 1'b1; cfg_we = 0; trig_we = 0; done_clr = 0; te_in = 0; pix_valid = 1;
        cfg_wdata = '0; trig_wdata = '0;
        exp_pre = 0; exp_act = 1; exp_post = 0;
        pulses = 0; data_err = 0; tim_err = 0; irq_cnt = 0; bad_trip = 0;
        exp_data = '0;
        tick(3);
        rst = 1'b0;
        tick(1);

        // R1 reset state
        check(lcd_cs_n == 1'b1 && lcd_wr_n == 1'b1, "R1 bus idle", {lcd_cs_n, lcd_wr_n}, 3);
        check(busy == 1'b0, "R1 busy", busy, 0);
        check(done_flag == 1'b0 && irq == 1'b0, "R1 done/irq", {done_flag, irq}, 0);

        // table walk: R3 R4 R8 R9 R10
        for (int i = 0; i < 6; i++) begin
            logic [27:0] v;
            v = VEC[i];
            write_cfg(v[27:24], v[23:20], v[19:16], v[15:12], 1'b1);
            arm_mon(v[11:8], v[7:4], v[3:0]);
            write_trig(1'b0, 1'b1);
            wait_done(4000);
            tick(2);
            check(pulses == FW, $sformatf("R8 strobe count vec %0d", i), pulses, FW);
            check(data_err == 0, $sformatf("R8 data order vec %0d", i), data_err, 0);
            check(tim_err == 0, $sformatf("R3 R4 phase lengths vec %0d", i), bad_trip,
                  int'(v[11:8]) * 100 + int'(v[7:4]) * 10 + int'(v[3:0]));
            check(done_flag && !busy, $sformatf("R9 done vec %0d", i), {done_flag, busy}, 2);
            check(irq_cnt == 1, $sformatf("R9 irq pulses vec %0d", i), irq_cnt, 1);
            clear_done($sformatf("R10 clear vec %0d", i));
        end

        // R2 trigger dropped while disabled
        write_cfg(0, 0, 1, 0, 1'b0);
        arm_mon(0, 1, 0);
        write_trig(1'b0, 1'b1);
        tick(30);
        check(busy == 1'b0 && pulses == 0, "R2 disabled trigger", pulses, 0);
        write_cfg(0, 0, 1, 0, 1'b1);
        tick(20);
        check(busy == 1'b0 && pulses == 0, "R2 no late start", busy, 0);

        // R6 trigger during a frame ignored
        write_cfg(3, 3, 4, 2, 1'b1);
        arm_mon(6, 4, 2);
        write_trig(1'b0, 1'b1);
        tick(3);
        check(busy == 1'b1, "R6 frame running", busy, 1);
        write_trig(1'b0, 1'b1);
        wait_done(4000);
        tick(100);
        check(pulses == FW && busy == 1'b0, "R6 single frame", pulses, FW);
        check(irq_cnt == 1, "R6 single irq", irq_cnt, 1);
        clear_done("R10 clear after R6");

        // R5 tearing-edge mode
        write_cfg(0, 0, 1, 0, 1'b1);
        arm_mon(0, 1, 0);
        write_trig(1'b1, 1'b1);
        tick(20);
        check(busy == 1'b0 && pulses == 0, "R5 waits for edge", pulses, 0);
        te_in = 1'b1;
        tick(1);
        check(busy == 1'b1, "R5 starts on edge", busy, 1);
        tick(3);
        te_in = 1'b0;
        wait_done(4000);
        tick(2);
        check(pulses == FW && data_err == 0, "R5 edge frame", pulses, FW);
        clear_done("R10 clear after R5");

        // R7 request consumed
        te_in = 1'b1;
        tick(4);
        te_in = 1'b0;
        tick(30);
        check(busy == 1'b0 && pulses == FW, "R7 no restart", pulses, FW);
        check(done_flag == 1'b0, "R7 no done", done_flag, 0);

        // R11 stream stall
        write_trig(1'b0, 1'b0);
        pix_valid = 1'b0;
        arm_mon(0, 1, 0);
        write_trig(1'b0, 1'b1);
        tick(20);
        check(busy == 1'b1 && lcd_cs_n == 1'b1, "R11 holds without data", {busy, lcd_cs_n}, 3);
        check(pulses == 0, "R11 no strobe", pulses, 0);
        pix_valid = 1'b1;
        wait_done(4000);
        tick(2);
        check(pulses == FW && data_err == 0, "R11 resumes", pulses, FW);

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule